// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides where a memory access lands when system-management RAM protection is in play. It holds two byte-wide control registers: a main control register with a global enable, an open bit and a lock bit, and an extended register with a high-enable bit, a TSEG enable and a two-bit TSEG size code. It also holds a 16-bit extended-size register that firmware uses to discover how many megabytes the fourth size code stands for. Registers are written one byte at a time through a select, a data byte and a per-bit write mask.

For every access the block takes the address, a flag that says whether the requester is in SMM, and the size of memory below 4 GiB. It returns a route code. Three regions are special: the 128 KiB legacy window at 0xA0000, a 128 KiB high alias at 0xFEDA0000, and the TSEG window at the top of low memory. Outside these regions, addresses below the low-memory size go to RAM and all others go to PCI. Route 2 tells the fabric to return all ones on a read and to discard a write.

The lock bit makes the configuration permanent until reset. Setting it clears the open bit in the same update and freezes both control registers.

Top module: `smram_tseg_ctl`

## Requirements
- R1: After reset the main control register and the extended register read 0x00. The extended-size register reads 0xFFFF when the EXT_MB parameter is non-zero and 0x0000 otherwise.
- R2: Register select 0 is the main control register (bit0 global enable, bit1 open, bit2 lock). Select 1 is the extended register (bit0 high enable, bit1 TSEG enable, bits 3:2 size code). Selects 2 and 3 are the low and high bytes of the extended-size register. A write changes only the bits whose cfg_wmask bit is 1. Bits above the defined fields always read 0.
- R3: A write that leaves the lock bit set also leaves the open bit clear. From then until reset, writes to select 0 and select 1 change nothing.
- R4: A non-SMM access inside 0xA0000..0xBFFFF routes to RAM (code 0) only when open=1 and high enable=0. In every other case it routes to PCI (code 1).
- R5: A non-SMM access inside 0xFEDA0000..0xFEDBFFFF routes to RAM only when open=1 and high enable=1. Otherwise it routes to PCI.
- R6: An SMM access goes to RAM in two cases: in the legacy window when global enable=1 and high enable=0, and in the high alias when global enable=1 and high enable=1. Any other SMM access to these windows follows the non-SMM rule.
- R7: TSEG size is zero unless both TSEG enable and global enable are 1. When both are 1, size codes 0, 1 and 2 give 1, 2 and 8 MiB. Code 3 gives EXT_MB MiB, or zero when EXT_MB exceeds EXT_MB_MAX.
- R8: For a non-zero TSEG size S and low-memory size B, addresses in [B-S, B) route to black hole (code 2) for non-SMM accesses and to RAM for SMM accesses.
- R9: Any other address routes to RAM if it is below B and to PCI otherwise, whatever the SMM flag.
- R10: When EXT_MB is non-zero and a write to select 2 or 3 leaves the extended-size register at 0xFFFF, the register takes the value EXT_MB instead. Any other written value is kept as written.
- R11: A register write changes the route from the clock cycle after the write edge; during the write cycle the old setting applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register byte write strobe |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 8 | Write data byte |
| cfg_wmask | input | 8 | Per-bit write mask (1 = write the bit) |
| cfg_rsel | input | 2 | Register select for reads |
| cfg_rdata | output | 8 | Read data for cfg_rsel |
| acc_smm | input | 1 | Access is made in SMM |
| acc_addr | input | ADDR_W | Access address |
| below_4g | input | ADDR_W | Size of memory below 4 GiB (B) |
| acc_route | output | 2 | 0 RAM, 1 PCI, 2 black hole |

## Verification
The route is checked over every combination of global enable, open, high enable, TSEG enable and size code. Each combination is probed at the edges of the legacy window, the high alias, the TSEG window and the low-memory limit, with and without SMM. This separates the open-bit view from the SMM view and shows when TSEG is active. Probes one byte below, at the start of, and at the end of each window catch off-by-one bounds and a wrong size decode. Separate register sequences cover the partial write mask, a lock written together with open, writes after lock, and the extended-size query written through each byte lane.

// File: rtl/smtg_pkg.sv
package smtg_pkg;

    typedef enum logic [1:0] {
        RT_RAM  = 2'd0,
        RT_PCI  = 2'd1,
        RT_HOLE = 2'd2
    } route_e;

    // main control register
    typedef struct packed {
        logic [4:0] rsvd;
        logic       lock;
        logic       open;
        logic       gen;
    } ctl_t;

    // extended control register
    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] szc;
        logic       ten;
        logic       hen;
    } ext_t;

    localparam logic [1:0] SEL_CTL   = 2'd0;
    localparam logic [1:0] SEL_EXT   = 2'd1;
    localparam logic [1:0] SEL_SZ_LO = 2'd2;
    localparam logic [1:0] SEL_SZ_HI = 2'd3;

    localparam logic [7:0] CTL_WM_FREE = 8'h07;
    localparam logic [7:0] CTL_WM_LCK  = 8'h00;
    localparam logic [7:0] EXT_WM_FREE = 8'h0F;
    localparam logic [7:0] EXT_WM_LCK  = 8'h00;

    localparam logic [15:0] SIZE_QUERY = 16'hFFFF;

    localparam logic [31:0] LEGACY_BASE = 32'h000A_0000;
    localparam logic [31:0] HIGH_BASE   = 32'hFEDA_0000;
    localparam logic [31:0] WIN_BYTES   = 32'h0002_0000;

    // TSEG size in MiB from the enables and the size code
    function automatic logic [15:0] tseg_mbytes(input logic active,
                                                input logic [1:0] code,
                                                input int unsigned emb,
                                                input int unsigned emax);
        logic [15:0] mb;
        if (!active) begin
            mb = 16'd0;
        end else begin
            case (code)
                2'd0:    mb = 16'd1;
                2'd1:    mb = 16'd2;
                2'd2:    mb = 16'd8;
                default: mb = (emb > emax) ? 16'd0 : 16'(emb);
            endcase
        end
        return mb;
    endfunction

endpackage

// File: rtl/smtg_ctl_regs.sv
module smtg_ctl_regs
    import smtg_pkg::*;
#(
    parameter int unsigned EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  wr_mask,
    output ctl_t        ctl_q,
    output ext_t        ext_q,
    output logic [15:0] size_q
);

    localparam logic [15:0] SIZE_RST = (EXT_MB != 0) ? SIZE_QUERY : 16'h0000;

    logic [7:0]  ctl_m, ext_m;
    ctl_t        ctl_nx;
    ext_t        ext_nx;
    logic [15:0] size_nx;

    always_comb begin
        ctl_m = wr_mask & (ctl_q.lock ? CTL_WM_LCK : CTL_WM_FREE);
        ext_m = wr_mask & (ctl_q.lock ? EXT_WM_LCK : EXT_WM_FREE);

        ctl_nx  = ctl_q;
        ext_nx  = ext_q;
        size_nx = size_q;

        if (wr_en) begin
            case (wr_sel)
                SEL_CTL: begin
                    ctl_nx = ctl_t'((ctl_q & ~ctl_m) | (wr_data & ctl_m));
                    if (ctl_nx.lock) ctl_nx.open = 1'b0;
                end
                SEL_EXT: ext_nx = ext_t'((ext_q & ~ext_m) | (wr_data & ext_m));
                SEL_SZ_LO: size_nx[7:0]  = (size_q[7:0]  & ~wr_mask) | (wr_data & wr_mask);
                default:   size_nx[15:8] = (size_q[15:8] & ~wr_mask) | (wr_data & wr_mask);
            endcase
            if (wr_sel[1] && (EXT_MB != 0) && (size_nx == SIZE_QUERY))
                size_nx = 16'(EXT_MB);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ext_q  <= '0;
            size_q <= SIZE_RST;
        end else begin
            ctl_q  <= ctl_nx;
            ext_q  <= ext_nx;
            size_q <= size_nx;
        end
    end

endmodule

// File: rtl/smtg_route.sv
module smtg_route
    import smtg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              gen,
    input  logic              open,
    input  logic              hen,
    input  logic [15:0]       tseg_mb,
    input  logic [ADDR_W-1:0] below_4g,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output route_e            route
);

    localparam int WIDE_W = ((ADDR_W > 36) ? ADDR_W : 36) + 1;

    logic [WIDE_W-1:0] a_w, b_w, t_w;
    logic in_leg, in_high, in_tseg;
    route_e plain;

    always_comb begin
        a_w = WIDE_W'(acc_addr);
        b_w = WIDE_W'(below_4g);
        t_w = WIDE_W'({tseg_mb, 20'h00000});

        in_leg  = (a_w >= WIDE_W'(LEGACY_BASE)) &&
                  (a_w <  WIDE_W'(LEGACY_BASE) + WIDE_W'(WIN_BYTES));
        in_high = (a_w >= WIDE_W'(HIGH_BASE)) &&
                  (a_w <  WIDE_W'(HIGH_BASE) + WIDE_W'(WIN_BYTES));
        in_tseg = (tseg_mb != 16'd0) && (a_w < b_w) && (a_w + t_w >= b_w);

        // view of an agent outside SMM
        if (in_leg)
            plain = (open && !hen) ? RT_RAM : RT_PCI;
        else if (in_high)
            plain = (open && hen) ? RT_RAM : RT_PCI;
        else if (in_tseg)
            plain = RT_HOLE;
        else
            plain = (a_w < b_w) ? RT_RAM : RT_PCI;

        // SMM overlays
        route = plain;
        if (acc_smm) begin
            if ((in_leg && gen && !hen) || (in_high && gen && hen) || in_tseg)
                route = RT_RAM;
        end
    end

endmodule

// File: rtl/smram_tseg_ctl.sv
module smram_tseg_ctl
    import smtg_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int unsigned EXT_MB     = 16,
    parameter int unsigned EXT_MB_MAX = 4095
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        cfg_wmask,
    input  logic [1:0]        cfg_rsel,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_smm,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] below_4g,
    output logic [1:0]        acc_route
);

    ctl_t        ctl_q;
    ext_t        ext_q;
    logic [15:0] size_q;
    logic [15:0] tseg_mb;
    route_e      route_w;

    smtg_ctl_regs #(.EXT_MB(EXT_MB)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .wr_mask (cfg_wmask),
        .ctl_q   (ctl_q),
        .ext_q   (ext_q),
        .size_q  (size_q)
    );

    assign tseg_mb = tseg_mbytes(ext_q.ten && ctl_q.gen, ext_q.szc, EXT_MB, EXT_MB_MAX);

    smtg_route #(.ADDR_W(ADDR_W)) u_route (
        .gen      (ctl_q.gen),
        .open     (ctl_q.open),
        .hen      (ext_q.hen),
        .tseg_mb  (tseg_mb),
        .below_4g (below_4g),
        .acc_addr (acc_addr),
        .acc_smm  (acc_smm),
        .route    (route_w)
    );

    assign acc_route = route_w;

    always_comb begin
        case (cfg_rsel)
            SEL_CTL:   cfg_rdata = ctl_q;
            SEL_EXT:   cfg_rdata = ext_q;
            SEL_SZ_LO: cfg_rdata = size_q[7:0];
            default:   cfg_rdata = size_q[15:8];
        endcase
    end

endmodule

// File: rtl/smtg_checker.sv
module smtg_checker
    import smtg_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int unsigned EXT_MB = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              acc_smm,
    input logic [ADDR_W-1:0] acc_addr,
    input ctl_t              ctl_q,
    input ext_t              ext_q,
    input logic [15:0]       size_q,
    input route_e            route
);

    logic in_leg;
    assign in_leg = (64'(acc_addr) >= 64'h000A_0000) && (64'(acc_addr) <= 64'h000B_FFFF);

    a_r3_lock_closes: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |-> !ctl_q.open);

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> ctl_q.lock);

    a_r3_ext_frozen: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> $stable(ext_q));

    a_r8_hole_nonsmm: assert property (@(posedge clk) disable iff (rst)
        (route == RT_HOLE) |-> !acc_smm);

    a_r4_closed_legacy: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.open && !acc_smm && in_leg) |-> (route == RT_PCI));

    a_r10_query_replaced: assert property (@(posedge clk) disable iff (rst)
        ((EXT_MB != 0) && $past(!rst) && $past(wr_en && wr_sel[1])) |-> (size_q != SIZE_QUERY));

endmodule

bind smram_tseg_ctl smtg_checker #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_sel),
    .acc_smm  (acc_smm),
    .acc_addr (acc_addr),
    .ctl_q    (ctl_q),
    .ext_q    (ext_q),
    .size_q   (size_q),
    .route    (route_w)
);

// File: tb/test_smram_tseg_ctl.sv
module test_smram_tseg_ctl;

    localparam int AW  = 32;
    localparam int EMB = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [1:0]    sel, rsel;
    logic [7:0]    wdata, wmask, rdata;
    logic          smm;
    logic [AW-1:0] addr, below;
    logic [1:0]    route;

    always #5 clk = ~clk;

    smram_tseg_ctl #(.ADDR_W(AW), .EXT_MB(EMB), .EXT_MB_MAX(4095)) i_smram_tseg_ctl (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_sel(sel), .cfg_wdata(wdata),
        .cfg_wmask(wmask), .cfg_rsel(rsel), .cfg_rdata(rdata), .acc_smm(smm),
        .acc_addr(addr), .below_4g(below), .acc_route(route)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0]  m_ctl, m_ext;
    logic [15:0] m_sz;

    always @(posedge clk) begin
        logic [7:0] m;
        if (rst) begin
            m_ctl = 8'h00;
            m_ext = 8'h00;
            m_sz  = (EMB != 0) ? 16'hFFFF : 16'h0000;
        end else if (wr_en) begin
            case (sel)
                2'd0: if (!m_ctl[2]) begin
                    m = wmask & 8'h07;
                    m_ctl = (m_ctl & ~m) | (wdata & m);
                    if (m_ctl[2]) m_ctl[1] = 1'b0;
                end
                2'd1: if (!m_ctl[2]) begin
                    m = wmask & 8'h0F;
                    m_ext = (m_ext & ~m) | (wdata & m);
                end
                2'd2: m_sz[7:0]  = (m_sz[7:0]  & ~wmask) | (wdata & wmask);
                default: m_sz[15:8] = (m_sz[15:8] & ~wmask) | (wdata & wmask);
            endcase
            if (sel[1] && EMB != 0 && m_sz == 16'hFFFF) m_sz = EMB;
        end
    end

    function automatic longint exp_mb();
        if (!(m_ext[1] && m_ctl[0])) return 0;
        case (m_ext[3:2])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return EMB;
        endcase
    endfunction

    function automatic logic [1:0] exp_route(input logic [AW-1:0] a, input logic s,
                                             output string tag);
        longint la = longint'(a);
        longint lb = longint'(below);
        longint t  = exp_mb() * 64'h10_0000;
        bit leg = (la >= 64'hA0000) && (la < 64'hC0000);
        bit hi  = (la >= 64'hFEDA0000) && (la < 64'hFEDC0000);
        bit ts  = (t != 0) && (la < lb) && (la + t >= lb);
        bit g = m_ctl[0], o = m_ctl[1], h = m_ext[0];
        if (s) begin
            if ((leg && g && !h) || (hi && g && h)) begin tag = "R6"; return 2'd0; end
            if (ts) begin tag = "R8"; return 2'd0; end
        end
        if (leg) begin tag = "R4"; return (o && !h) ? 2'd0 : 2'd1; end
        if (hi)  begin tag = "R5"; return (o && h) ? 2'd0 : 2'd1; end
        if (ts)  begin tag = "R8"; return 2'd2; end
        tag = "R9";
        return (la < lb) ? 2'd0 : 2'd1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] r);
        case (r)
            2'd0: return m_ctl;
            2'd1: return m_ext;
            2'd2: return m_sz[7:0];
            default: return m_sz[15:8];
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        string tg;
        logic [1:0] e;
        if (!rst && !done) begin
            e = exp_route(addr, smm, tg);
            check({tg, " R7 route"}, route, e);
            check((rsel < 2) ? "R2 R3 read" : "R10 read", rdata, exp_read(rsel));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic [7:0] m);
        wr_en = 1'b1; sel = s; wdata = d; wmask = m;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic acc(input logic [AW-1:0] a, input logic s, input logic [1:0] r);
        addr = a; smm = s; rsel = r;
        tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin
        longint t;
        logic [AW-1:0] pts [13];
        wr_en = 0; sel = 0; wdata = 0; wmask = 0; rsel = 0; smm = 0;
        addr = '0; below = 32'h8000_0000;
        do_reset();

        // R1 reset values
        rsel = 2'd0; #1 check("R1 ctl", rdata, 8'h00);
        rsel = 2'd1; #1 check("R1 ext", rdata, 8'h00);
        rsel = 2'd2; #1 check("R1 size lo", rdata, 8'hFF);
        rsel = 2'd3; #1 check("R1 size hi", rdata, 8'hFF);
        addr = 32'h000A_0000; smm = 0; #1 check("R1 legacy closed", route, 2'd1);

        // R2 partial mask
        wr(2'd0, 8'hFF, 8'h02);
        rsel = 2'd0; #1 check("R2 masked write", rdata, 8'h02);
        wr(2'd1, 8'hF5, 8'hFF);
        rsel = 2'd1; #1 check("R2 reserved bits", rdata, 8'h05);
        do_reset();

        // R11 timing of a new setting
        wr(2'd0, 8'h01, 8'hFF);
        addr = 32'h000B_0000; smm = 0;
        wr_en = 1'b1; sel = 2'd0; wdata = 8'h03; wmask = 8'hFF;
        #1 check("R11 old setting during write", route, 2'd1);
        tick();
        wr_en = 1'b0;
        #1 check("R11 new setting after write", route, 2'd0);
        do_reset();

        // full sweep over enables, size codes, addresses and SMM
        for (int c = 0; c < 64; c++) begin
            wr(2'd0, {6'b0, c[1], c[0]}, 8'hFF);
            wr(2'd1, {4'b0, c[5:4], c[3], c[2]}, 8'hFF);
            t = exp_mb() * 64'h10_0000;
            if (t == 0) t = 64'h10_0000;
            pts[0]  = 32'h0009_FFFF; pts[1]  = 32'h000A_0000;
            pts[2]  = 32'h000B_FFFF; pts[3]  = 32'h000C_0000;
            pts[4]  = 32'hFED9_FFFF; pts[5]  = 32'hFEDA_0000;
            pts[6]  = 32'hFEDB_FFFF; pts[7]  = 32'hFEDC_0000;
            pts[8]  = AW'(64'(below) - t - 1); pts[9] = AW'(64'(below) - t);
            pts[10] = below - 1;     pts[11] = below;
            pts[12] = '0;
            for (int p = 0; p < 13; p++) begin
                for (int s = 0; s < 2; s++) acc(pts[p], s[0], 2'(p));
            end
        end
        do_reset();

        // R3 lock written together with open
        wr(2'd1, 8'h03, 8'hFF);
        wr(2'd0, 8'h07, 8'hFF);
        rsel = 2'd0; #1 check("R3 open cleared by lock", rdata, 8'h05);
        addr = 32'h000A_0000; smm = 0; #1 check("R3 R4 legacy to PCI after lock", route, 2'd1);
        wr(2'd0, 8'h02, 8'hFF);
        rsel = 2'd0; #1 check("R3 ctl frozen", rdata, 8'h05);
        wr(2'd1, 8'h0C, 8'hFF);
        rsel = 2'd1; #1 check("R3 ext frozen", rdata, 8'h03);
        addr = below - 1; smm = 0; #1 check("R8 hole while locked", route, 2'd2);
        smm = 1; #1 check("R8 SMM reaches TSEG", route, 2'd0);
        do_reset();
        rsel = 2'd0; #1 check("R1 lock cleared by reset", rdata, 8'h00);

        // R10 extended size query handling
        wr(2'd2, 8'hFF, 8'hFF);
        rsel = 2'd2; #1 check("R10 query replaced lo", rdata, 8'h10);
        rsel = 2'd3; #1 check("R10 query replaced hi", rdata, 8'h00);
        wr(2'd3, 8'h12, 8'hFF);
        wr(2'd2, 8'h34, 8'hFF);
        rsel = 2'd3; #1 check("R10 plain value kept", rdata, 8'h12);
        wr(2'd3, 8'hFF, 8'hFF);
        wr(2'd2, 8'hFF, 8'hFF);
        rsel = 2'd2; #1 check("R10 query via two bytes", rdata, 8'h10);

        // R7 code 3 uses EXT_MB megabytes
        wr(2'd0, 8'h01, 8'hFF);
        wr(2'd1, 8'h0E, 8'hFF);
        addr = below - 32'd16 * 32'h10_0000; smm = 0;
        #1 check("R7 extended size low edge", route, 2'd2);
        addr = addr - 1;
        #1 check("R7 below extended window", route, 2'd0);
        tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule